// File: doc/BRIEF.md
# Differential Clock Output Gating Controller

This block sits in the reference-clock domain of a clock fan-out buffer. For each of a parameterized number of differential outputs it decides whether the pair toggles, is parked at a driven level, or is released to high impedance. It gives a gated clock for each leg, a tri-state enable for each leg and a run flag.

The inputs are hardware enable pins, a stop request, a power-down request, a global polarity pin and quasi-static configuration bytes written by a serial management slave. One pin sets the active level of the enable, stop and power-down inputs together. The stop and power-down requests are synchronized and then filtered. Each output can be set either to obey the stop request or to keep running, and the parked level for each request can be chosen as driven or floating.

The block also merges three hardware mode pins with their configuration bits. The result is the effective bypass, divide-by-two and bandwidth selections that go to the PLL and divider logic outside this block. All state advances on the falling edge of the reference clock, so every gating change happens while the clock is low.

Top module: `diffclk_gate_ctrl`

## Requirements
- R1: With `pol_pin_i` = 0, the enable pins are active high and the stop and power-down pins are active low. With `pol_pin_i` = 1, all three polarities are inverted.
- R2: Output n runs only if its enable pin is at the active level and bit n of `cfg_oe_i` is 1. Otherwise `run_o[n]`, `en_t_o[n]` and `en_c_o[n]` are all 0, unless R5 parks the output at a driven level.
- R3: A stop or power-down level is accepted only after its synchronized sample is the same on two consecutive falling clock edges, for assertion and for deassertion. A level seen on only one falling edge is ignored. A two-edge level is accepted and reaches the outputs on the 5th falling edge after it appears. Stop may change at any time relative to the clock.
- R4: A change of an enable pin, or of a `cfg_oe_i` bit, reaches the outputs on the 3rd falling edge after it appears.
- R5: An accepted power-down overrides stop and enable. An accepted stop overrides enable for stoppable outputs.
- R6: When bit n of `cfg_stop_i` is 1, output n obeys stop. When it is 0, output n keeps its normal state while stop is accepted.
- R7: `cfg_mode_i[7]` sets the power-down park and `cfg_mode_i[6]` sets the stop park: 0 means driven, 1 means both legs floated. In a driven park the true leg is enabled and held high.
- R8: In a driven park the complement leg is driven low when parameter `PARK_COMP_FLOAT` is 0, and floated when it is 1.
- R9: `pll_o` = `pll_pin_i` & `cfg_mode_i[1]` (0 = bypass). `div2_no` = `div2_pin_ni` & `cfg_mode_i[0]` (0 = divide by two). `hibw_no` = `hibw_pin_ni` & `cfg_mode_i[2]` (0 = high bandwidth). The polarity pin has no effect on these outputs.
- R10: A running output gives `clk_t_o` equal to the clock and `clk_c_o` equal to its inverse. A parked-driven output holds `clk_t_o` high and `clk_c_o` low. Run state changes only at a falling clock edge.
- R11: While reset is asserted, every output is floated and not running, and stop and power-down are taken as inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; state advances on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_pin_i | input | NUM_OUT | Hardware output-enable pins |
| stop_pin_i | input | 1 | Stop request pin, asynchronous |
| pd_pin_i | input | 1 | Power-down request pin |
| pol_pin_i | input | 1 | Global control polarity select |
| div2_pin_ni | input | 1 | Hardware divide-by-two select, active low |
| pll_pin_i | input | 1 | Hardware PLL select, 0 = bypass |
| hibw_pin_ni | input | 1 | Hardware high-bandwidth select, active low |
| cfg_mode_i | input | 8 | Mode byte: [0] div2, [1] PLL, [2] bandwidth, [6] stop park float, [7] power-down park float |
| cfg_oe_i | input | NUM_OUT | Per-output software enable |
| cfg_stop_i | input | NUM_OUT | Per-output stoppable select |
| run_o | output | NUM_OUT | Output toggling |
| clk_t_o | output | NUM_OUT | Gated true-leg clock |
| clk_c_o | output | NUM_OUT | Gated complement-leg clock |
| en_t_o | output | NUM_OUT | True-leg driver enable |
| en_c_o | output | NUM_OUT | Complement-leg driver enable |
| div2_no | output | 1 | Effective divide-by-two, active low |
| pll_o | output | 1 | Effective PLL select, 0 = bypass |
| hibw_no | output | 1 | Effective high bandwidth, active low |

## Verification
A behavioural model tracks every falling edge and is compared at both clock phases. It is driven with patterns that separate its mechanisms:
- Stop pulses one edge long and two edges long tell filtering apart from plain synchronizing.
- A mixed stoppable mask with stop held shows per-output selection.
- Power-down applied on top of a held stop shows priority.
- Patterns where the enable pin and the enable bit disagree show the AND.
- Repeating the sequence under the inverted polarity setting shows that every control input flips.

A second instance with the floating complement park checks the parameter variant. A sweep of all 64 combinations of mode pins and mode bits checks the merged mode outputs.

// File: rtl/ogc_pkg.sv
`timescale 1ns/1ps
package ogc_pkg;
   typedef enum logic [1:0] {
      LANE_OFF  = 2'd0,
      LANE_RUN  = 2'd1,
      LANE_HOLD = 2'd2
   } lane_st_e;

   localparam int MODE_DIV2_BIT   = 0;
   localparam int MODE_PLL_BIT    = 1;
   localparam int MODE_BW_BIT     = 2;
   localparam int MODE_STOPFL_BIT = 6;
   localparam int MODE_PDFL_BIT   = 7;
   localparam int MODE_W          = 8;
endpackage

// File: rtl/ogc_sync.sv
`timescale 1ns/1ps
module ogc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] ff_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("ogc_sync needs at least two stages");
      end
   endgenerate

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ff_q <= {STAGES{RST_VAL}};
      end else begin
         ff_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) begin
            ff_q[i] <= ff_q[i-1];
         end
      end
   end

   assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/ogc_deglitch.sv
`timescale 1ns/1ps
module ogc_deglitch #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_LEN     = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic act_i,
   output logic acc_o
);
   localparam int HIST_W = DEB_LEN - 1;

   logic              smp;
   logic [HIST_W-1:0] hist_q;
   logic              all_hi, all_lo;

   generate
      if (DEB_LEN < 2) begin : g_bad
         $error("ogc_deglitch needs a window of at least two edges");
      end
   endgenerate

   ogc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (act_i),
      .q_o   (smp)
   );

   assign all_hi = smp & (&hist_q);
   assign all_lo = ~smp & ~(|hist_q);

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hist_q <= '0;
         acc_o  <= 1'b0;
      end else begin
         hist_q[0] <= smp;
         for (int i = 1; i < HIST_W; i++) begin
            hist_q[i] <= hist_q[i-1];
         end
         if (all_hi) begin
            acc_o <= 1'b1;
         end else if (all_lo) begin
            acc_o <= 1'b0;
         end
      end
   end

   // R3: the accepted level moves only to a level already seen twice in a row
   a_r3_accept_needs_stable: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (acc_o != $past(acc_o)) |-> ($past(smp) == acc_o && $past(hist_q[0]) == acc_o));
endmodule

// File: rtl/ogc_lane.sv
`timescale 1ns/1ps
module ogc_lane
   import ogc_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter bit PARK_COMP_FLOAT = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic oe_req_i,
   input  logic pd_acc_i,
   input  logic stop_acc_i,
   input  logic stoppable_i,
   input  logic pd_float_i,
   input  logic stop_float_i,
   output logic run_o,
   output logic clk_t_o,
   output logic clk_c_o,
   output logic en_t_o,
   output logic en_c_o
);
   logic     oe_s;
   lane_st_e st_q, st_d;

   ogc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_oe_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (oe_req_i),
      .q_o   (oe_s)
   );

   always_comb begin
      if (pd_acc_i) begin
         st_d = pd_float_i ? LANE_OFF : LANE_HOLD;
      end else if (stop_acc_i && stoppable_i) begin
         st_d = stop_float_i ? LANE_OFF : LANE_HOLD;
      end else if (oe_s) begin
         st_d = LANE_RUN;
      end else begin
         st_d = LANE_OFF;
      end
   end

   // state only moves on the falling edge, so the true leg is low when gating changes
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q <= LANE_OFF;
      end else begin
         st_q <= st_d;
      end
   end

   assign run_o   = (st_q == LANE_RUN);
   assign en_t_o  = (st_q != LANE_OFF);
   assign clk_t_o = (st_q == LANE_RUN) ? clk_i : (st_q == LANE_HOLD);
   assign clk_c_o = (st_q == LANE_RUN) & ~clk_i;

   generate
      if (PARK_COMP_FLOAT) begin : g_comp_float
         assign en_c_o = (st_q == LANE_RUN);
      end else begin : g_comp_drive
         assign en_c_o = (st_q != LANE_OFF);
      end
   endgenerate

   // R5: power-down always stops the output at the next edge
   a_r5_pd_wins: assert property (@(negedge clk_i) disable iff (!rst_ni)
      pd_acc_i |=> !run_o);

   // R6: a free-running output ignores an accepted stop
   a_r6_free_runs: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!pd_acc_i && stop_acc_i && !stoppable_i && oe_s) |=> run_o);

   // R2: a disabled output with no override has both legs released
   a_r2_off_floats: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!oe_s && !pd_acc_i && !(stop_acc_i && stoppable_i)) |=> (!en_t_o && !en_c_o));

   // R7: floating stop park releases the true leg
   a_r7_stop_float: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!pd_acc_i && stop_acc_i && stoppable_i && stop_float_i) |=> !en_t_o);
endmodule

// File: rtl/diffclk_gate_ctrl.sv
`timescale 1ns/1ps
module diffclk_gate_ctrl
   import ogc_pkg::*;
#(
   parameter int NUM_OUT         = 8,
   parameter int SYNC_STAGES     = 2,
   parameter int DEB_LEN         = 2,
   parameter bit PARK_COMP_FLOAT = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_OUT-1:0] oe_pin_i,
   input  logic               stop_pin_i,
   input  logic               pd_pin_i,
   input  logic               pol_pin_i,
   input  logic               div2_pin_ni,
   input  logic               pll_pin_i,
   input  logic               hibw_pin_ni,
   input  logic [MODE_W-1:0]  cfg_mode_i,
   input  logic [NUM_OUT-1:0] cfg_oe_i,
   input  logic [NUM_OUT-1:0] cfg_stop_i,
   output logic [NUM_OUT-1:0] run_o,
   output logic [NUM_OUT-1:0] clk_t_o,
   output logic [NUM_OUT-1:0] clk_c_o,
   output logic [NUM_OUT-1:0] en_t_o,
   output logic [NUM_OUT-1:0] en_c_o,
   output logic               div2_no,
   output logic               pll_o,
   output logic               hibw_no
);
   logic [NUM_OUT-1:0] oe_req;
   logic               pd_act, stop_act;
   logic               pd_acc, stop_acc;
   logic               unused_mode;

   generate
      if (NUM_OUT < 1 || NUM_OUT > MODE_W) begin : g_bad_n
         $error("NUM_OUT must lie between 1 and the configuration byte width");
      end
   endgenerate

   assign oe_req   = (oe_pin_i ^ {NUM_OUT{pol_pin_i}}) & cfg_oe_i;
   assign pd_act   = ~(pd_pin_i ^ pol_pin_i);
   assign stop_act = ~(stop_pin_i ^ pol_pin_i);

   ogc_deglitch #(.SYNC_STAGES(SYNC_STAGES), .DEB_LEN(DEB_LEN)) u_pd_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .act_i (pd_act),
      .acc_o (pd_acc)
   );

   ogc_deglitch #(.SYNC_STAGES(SYNC_STAGES), .DEB_LEN(DEB_LEN)) u_stop_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .act_i (stop_act),
      .acc_o (stop_acc)
   );

   for (genvar n = 0; n < NUM_OUT; n++) begin : g_lane
      ogc_lane #(.SYNC_STAGES(SYNC_STAGES), .PARK_COMP_FLOAT(PARK_COMP_FLOAT)) u_lane (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .oe_req_i    (oe_req[n]),
         .pd_acc_i    (pd_acc),
         .stop_acc_i  (stop_acc),
         .stoppable_i (cfg_stop_i[n]),
         .pd_float_i  (cfg_mode_i[MODE_PDFL_BIT]),
         .stop_float_i(cfg_mode_i[MODE_STOPFL_BIT]),
         .run_o       (run_o[n]),
         .clk_t_o     (clk_t_o[n]),
         .clk_c_o     (clk_c_o[n]),
         .en_t_o      (en_t_o[n]),
         .en_c_o      (en_c_o[n])
      );
   end

   assign div2_no = div2_pin_ni & cfg_mode_i[MODE_DIV2_BIT];
   assign pll_o   = pll_pin_i   & cfg_mode_i[MODE_PLL_BIT];
   assign hibw_no = hibw_pin_ni & cfg_mode_i[MODE_BW_BIT];

   assign unused_mode = ^cfg_mode_i[5:3];
endmodule

// File: tb/diffclk_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module diffclk_gate_ctrl_tb_top;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] oe_pin = 8'hFF;
   logic         stop_pin = 1'b1, pd_pin = 1'b1, pol = 1'b0;
   logic         div2_n = 1'b1, pll = 1'b1, hibw_n = 1'b1;
   logic [7:0]   cfg_mode = 8'h07;
   logic [N-1:0] cfg_oe = 8'hFF, cfg_stop = 8'h00;

   logic [N-1:0] run, clk_t, clk_c, en_t, en_c;
   logic [N-1:0] f_run, f_clk_t, f_clk_c, f_en_t, f_en_c;
   logic         div2_o, pll_o, hibw_o, f_div2, f_pll, f_hibw;

   int vectors = 0, miscompares = 0;
   bit done = 1'b0;
   string cur_tag = "R11";

   always #2.5 clk = ~clk;

   diffclk_gate_ctrl #(.NUM_OUT(N)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .oe_pin_i(oe_pin), .stop_pin_i(stop_pin),
      .pd_pin_i(pd_pin), .pol_pin_i(pol), .div2_pin_ni(div2_n), .pll_pin_i(pll),
      .hibw_pin_ni(hibw_n), .cfg_mode_i(cfg_mode), .cfg_oe_i(cfg_oe),
      .cfg_stop_i(cfg_stop), .run_o(run), .clk_t_o(clk_t), .clk_c_o(clk_c),
      .en_t_o(en_t), .en_c_o(en_c), .div2_no(div2_o), .pll_o(pll_o), .hibw_no(hibw_o)
   );

   diffclk_gate_ctrl #(.NUM_OUT(N), .PARK_COMP_FLOAT(1'b1)) dut_flt (
      .clk_i(clk), .rst_ni(rst_n), .oe_pin_i(oe_pin), .stop_pin_i(stop_pin),
      .pd_pin_i(pd_pin), .pol_pin_i(pol), .div2_pin_ni(div2_n), .pll_pin_i(pll),
      .hibw_pin_ni(hibw_n), .cfg_mode_i(cfg_mode), .cfg_oe_i(cfg_oe),
      .cfg_stop_i(cfg_stop), .run_o(f_run), .clk_t_o(f_clk_t), .clk_c_o(f_clk_c),
      .en_t_o(f_en_t), .en_c_o(f_en_c), .div2_no(f_div2), .pll_o(f_pll), .hibw_no(f_hibw)
   );

   // ---------------- reference model: 0 off, 1 run, 2 parked driven
   int           ms [N];
   bit           acc_pd, acc_st;
   bit           pd_q[$], st_q[$];
   logic [N-1:0] oe_q[$];
   bit           m_pda, m_sta, m_dump;
   logic [N-1:0] m_oer, m_dumpv;

   task automatic model_reset();
      for (int n = 0; n < N; n++) ms[n] = 0;
      acc_pd = 1'b0;
      acc_st = 1'b0;
      pd_q = '{1'b0, 1'b0, 1'b0, 1'b0};
      st_q = '{1'b0, 1'b0, 1'b0, 1'b0};
      oe_q = '{8'h00, 8'h00, 8'h00, 8'h00};
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare(bit hi);
      logic [N-1:0] e_run, e_t, e_c, e_ct, e_cc, e_fc;
      for (int n = 0; n < N; n++) begin
         e_run[n] = (ms[n] == 1);
         e_t[n]   = (ms[n] != 0);
         e_c[n]   = (ms[n] != 0);
         e_fc[n]  = (ms[n] == 1);
         e_ct[n]  = (ms[n] == 1) ? hi : (ms[n] == 2);
         e_cc[n]  = (ms[n] == 1) ? ~hi : 1'b0;
      end
      vectors++;
      if (run !== e_run || en_t !== e_t || en_c !== e_c || clk_t !== e_ct || clk_c !== e_cc) begin
         miscompares++;
         $display("FAIL %s/R10: actual run=%h t=%h c=%h ct=%h cc=%h expected run=%h t=%h c=%h ct=%h cc=%h at %0t",
                  cur_tag, run, en_t, en_c, clk_t, clk_c, e_run, e_t, e_c, e_ct, e_cc, $time);
      end
      vectors++;
      if (f_run !== e_run || f_en_t !== e_t || f_en_c !== e_fc || f_clk_t !== e_ct || f_clk_c !== e_cc) begin
         miscompares++;
         $display("FAIL %s/R8: actual run=%h t=%h c=%h expected run=%h t=%h c=%h at %0t",
                  cur_tag, f_run, f_en_t, f_en_c, e_run, e_t, e_fc, $time);
      end
   endtask

   initial model_reset();

   always @(negedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         m_pda = pol ? pd_pin : ~pd_pin;
         m_sta = pol ? stop_pin : ~stop_pin;
         m_oer = (oe_pin ^ {N{pol}}) & cfg_oe;
         pd_q.push_front(m_pda);  m_dump  = pd_q.pop_back();
         st_q.push_front(m_sta);  m_dump  = st_q.pop_back();
         oe_q.push_front(m_oer);  m_dumpv = oe_q.pop_back();
         for (int n = 0; n < N; n++) begin
            if (acc_pd)                     ms[n] = cfg_mode[7] ? 0 : 2;
            else if (acc_st && cfg_stop[n]) ms[n] = cfg_mode[6] ? 0 : 2;
            else                            ms[n] = oe_q[2][n] ? 1 : 0;
         end
         if (pd_q[2] == pd_q[3]) acc_pd = pd_q[2];
         if (st_q[2] == st_q[3]) acc_st = st_q[2];
      end
      #1;
      if (!done) compare(1'b0);
   end

   always @(posedge clk) begin
      #1;
      if (!done) compare(1'b1);
   end

   task automatic cyc(int k);
      repeat (k) @(posedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      #7;
      cur_tag = "R11";
      chk("R11 reset run", 32'(run), 32'h0);
      chk("R11 reset float", 32'({en_t, en_c}), 32'h0);
      cyc(3);
      rst_n = 1'b1;

      cur_tag = "R2";
      cyc(8);
      chk("R2 all running", 32'(run), 32'hFF);

      // R4: enable pin latency
      cur_tag = "R4";
      @(posedge clk); oe_pin[3] = 1'b0;
      @(negedge clk); @(negedge clk); #1;
      chk("R4 still running at 2nd edge", 32'(run[3]), 32'h1);
      @(negedge clk); #1;
      chk("R4 stopped at 3rd edge", 32'(run[3]), 32'h0);
      chk("R2 disabled floats", 32'({en_t[3], en_c[3]}), 32'h0);
      @(posedge clk); oe_pin[3] = 1'b1;
      cyc(6);

      cur_tag = "R2";
      @(posedge clk); cfg_oe = 8'h3C; oe_pin = 8'hF0;
      cyc(6);
      chk("R2 pin AND bit", 32'(run), 32'h30);
      @(posedge clk); cfg_oe = 8'hFF; oe_pin = 8'hFF;
      cyc(6);

      // R3: one-edge stop pulse, changed away from the edge
      cur_tag = "R3";
      @(posedge clk); cfg_stop = 8'hFF; cfg_mode = 8'h07;
      @(posedge clk); #1.3 stop_pin = 1'b0;
      @(posedge clk); #1.3 stop_pin = 1'b1;
      cyc(8);
      chk("R3 short stop ignored", 32'(run), 32'hFF);

      // R3: two-edge stop pulse
      @(posedge clk); stop_pin = 1'b0;
      @(posedge clk);
      @(posedge clk); stop_pin = 1'b1;
      repeat (3) @(negedge clk); #1;
      chk("R3 stop accepted at 5th edge", 32'(run), 32'h00);
      chk("R7 stop park driven", 32'(en_t), 32'hFF);
      @(negedge clk); #1;
      chk("R3 stop still held", 32'(run), 32'h00);
      @(negedge clk); #1;
      chk("R3 release accepted", 32'(run), 32'hFF);

      // R6 and R7: stoppable mask, floated stop park
      cur_tag = "R6";
      @(posedge clk); cfg_stop = 8'hA5; cfg_mode = 8'h47; stop_pin = 1'b0;
      cyc(8);
      chk("R6 mask run", 32'(run), 32'h5A);
      chk("R7 stop float", 32'(en_t), 32'h5A);
      @(posedge clk); cfg_mode = 8'h07;
      cyc(2);
      chk("R7 stop driven park", 32'(en_t), 32'hFF);

      // R5: power-down over stop, R8 complement park
      cur_tag = "R5";
      @(posedge clk); pd_pin = 1'b0;
      cyc(8);
      @(negedge clk); #1;
      chk("R5 pd stops all", 32'(run), 32'h00);
      chk("R7 pd driven true", 32'({en_t, clk_t}), 32'hFFFF);
      chk("R8 comp driven low", 32'({en_c, clk_c}), 32'hFF00);
      chk("R8 comp floated variant", 32'(f_en_c), 32'h00);
      @(posedge clk); cfg_mode = 8'h87;
      cyc(2);
      chk("R7 pd float", 32'(en_t), 32'h00);
      @(posedge clk); pd_pin = 1'b1; stop_pin = 1'b1; cfg_mode = 8'h07;
      cyc(8);
      chk("R5 all back", 32'(run), 32'hFF);
      @(posedge clk); #1;
      chk("R10 true leg follows clock", 32'(clk_t), 32'hFF);

      // R1: inverted polarity
      cur_tag = "R1";
      @(posedge clk); pol = 1'b1; oe_pin = 8'h00; stop_pin = 1'b0; pd_pin = 1'b0;
      cyc(10);
      chk("R1 inverted enable", 32'(run), 32'hFF);
      @(posedge clk); cfg_stop = 8'h0F; stop_pin = 1'b1;
      cyc(8);
      chk("R1 inverted stop", 32'(run), 32'hF0);
      @(posedge clk); pd_pin = 1'b1; cfg_mode = 8'h87;
      cyc(8);
      chk("R1 inverted pd", 32'(en_t), 32'h00);
      @(posedge clk); pd_pin = 1'b0; stop_pin = 1'b0; oe_pin = 8'h0F; cfg_mode = 8'h07;
      cyc(8);
      chk("R1 inverted pins disable", 32'(run), 32'hF0);
      @(posedge clk); pol = 1'b0; oe_pin = 8'hFF; stop_pin = 1'b1; pd_pin = 1'b1;
      cyc(8);
      chk("R1 back to normal", 32'(run), 32'hFF);

      // R9: mode merge sweep
      cur_tag = "R9";
      for (int i = 0; i < 64; i++) begin
         @(posedge clk);
         div2_n = i[0]; pll = i[1]; hibw_n = i[2];
         cfg_mode = {5'b00000, i[5:3]};
         pol = i[0] ^ i[3];
         #1;
         chk("R9 modes", 32'({div2_o, pll_o, hibw_o}),
             32'({i[0] & i[3], i[1] & i[4], i[2] & i[5]}));
      end
      @(posedge clk); pol = 1'b0;
      cyc(8);
      finish_run();
   end
endmodule